// File: doc/BRIEF.md
# Instruction Length, Cost and Skip Controller

This unit sits at the front of a small 16-bit processor's issue stage. It looks at the first word of each instruction and works out everything the sequencer needs before any operand is fetched. That covers the format (two-operand or single-operand extended), the raw opcode and operand fields, the number of words the instruction occupies, and how many cycles it will take. Operand codes that pull an extra word from the instruction stream each add one word and one cycle.

The unit also enforces the conditional-execution rule. When a comparison instruction reports a failed test, the instruction that follows must not run. That instruction still passes through the unit, so the program counter can step over it by its decoded length, but it is marked skipped and charged zero cycles. A sequencer can also force a skip directly. Results are registered and appear one cycle after an instruction is presented. The datapath that actually executes instructions is outside this block.

Top module: `instr_step_ctl`

## Requirements
- R1: After reset, out_valid and out_skip_next are 0.
- R2: If bits 3:0 are nonzero, the word is two-operand: out_nonbasic=0, out_opcode=bits 3:0, out_opnd_a=bits 9:4, out_opnd_b=bits 15:10, out_xop=0. If bits 3:0 are zero, it is extended: out_nonbasic=1, out_opcode=0, out_xop=bits 9:4, out_opnd_a=bits 15:10, out_opnd_b=0.
- R3: An operand code in 0x10..0x17, or equal to 0x1e or 0x1f, carries one extra word. out_len is 1 plus one for each such operand among those the format uses, so it is 1 to 3. out_pc_adv equals out_len for every instruction, whether skipped or not.
- R4: Opcode costs for an executed instruction, each plus one cycle per extra-word operand:
  - 1 cycle: 0x1 (move), 0x9 (and), 0xa (or), 0xb (xor).
  - 2 cycles: 0x2, 0x3, 0x4, 0x7, 0x8.
  - 3 cycles: 0x5, 0x6.
- R5: Test opcodes 0xc..0xf cost 2 plus operand words, plus 1 when in_test_fail is 1. A skipped instruction reports 0 cycles.
- R6: Extended opcode 0x01 (subroutine call) costs 2 plus 1 if its operand carries an extra word.
- R7: Extended opcodes 0x00 and 0x02..0x3f set out_illegal. They have length 1 and cost 1, or 0 when skipped.
- R8: A non-skipped test opcode with in_test_fail=1 sets out_skip_next. The next accepted instruction is then reported with out_skipped=1. in_test_fail is ignored for non-test opcodes.
- R9: in_skip_req=1 marks the presented instruction as skipped.
- R10: A skipped instruction never sets out_skip_next, even if it is a failing test. A pending skip is cleared by the instruction that consumes it.
- R11: Every result appears one cycle after in_valid. With in_valid low, out_valid is 0 next cycle and out_skip_next holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction word presented this cycle |
| in_word | input | 16 | First word of the instruction |
| in_test_fail | input | 1 | Test result for a test opcode: 1 means the test failed |
| in_skip_req | input | 1 | Force this instruction to be skipped |
| out_valid | output | 1 | Results below belong to the last presented word |
| out_nonbasic | output | 1 | Extended single-operand format |
| out_opcode | output | 4 | Two-operand opcode field |
| out_xop | output | 6 | Extended opcode field |
| out_opnd_a | output | 6 | First operand code |
| out_opnd_b | output | 6 | Second operand code |
| out_len | output | 2 | Instruction length in words |
| out_cycles | output | 3 | Cycle cost |
| out_pc_adv | output | 2 | Words by which to advance the program counter |
| out_skipped | output | 1 | Instruction is stepped over without executing |
| out_illegal | output | 1 | Reserved extended opcode |
| out_skip_next | output | 1 | Skip pending for the next accepted instruction |

## Verification
All decoded fields, length, cost and the skipped/illegal flags are due exactly one clock edge after the word is presented. The pending-skip flag changes on that same edge. The bench drives each word on a falling edge, lets one rising edge pass, and compares every output on the next falling edge before it presents the next word. Its independent model of the pending skip advances in that same step, so a skip armed by one word is checked on the very next word.

// File: rtl/instr_step_pkg.sv
package instr_step_pkg;

    typedef enum logic [3:0] {
        OP_EXT = 4'h0, OP_MOV = 4'h1, OP_ADD = 4'h2, OP_SUB = 4'h3,
        OP_MUL = 4'h4, OP_DIV = 4'h5, OP_REM = 4'h6, OP_SHL = 4'h7,
        OP_SHR = 4'h8, OP_AND = 4'h9, OP_IOR = 4'ha, OP_XOR = 4'hb,
        OP_TEQ = 4'hc, OP_TNE = 4'hd, OP_TGT = 4'he, OP_TBS = 4'hf
    } op_e;

    localparam logic [5:0] XOP_CALL = 6'h01;

    // base cycle cost of a two-operand opcode, operand words excluded
    function automatic logic [2:0] base_cost(input logic [3:0] opc);
        case (op_e'(opc))
            OP_MOV, OP_AND, OP_IOR, OP_XOR:         return 3'd1;
            OP_ADD, OP_SUB, OP_MUL, OP_SHL, OP_SHR: return 3'd2;
            OP_DIV, OP_REM:                         return 3'd3;
            OP_TEQ, OP_TNE, OP_TGT, OP_TBS:         return 3'd2;
            default:                                return 3'd0;
        endcase
    endfunction

    function automatic logic is_test_op(input logic [3:0] opc);
        return opc[3] & opc[2];
    endfunction

endpackage

// File: rtl/ctl_nxw.sv
// Flags an operand code that pulls one extra word from the instruction stream.
module ctl_nxw #(
    parameter int FLD_W = 6
) (
    input  logic [FLD_W-1:0] code,
    output logic             hit
);
    localparam logic [FLD_W-1:0] IDX_LO  = FLD_W'(16);
    localparam logic [FLD_W-1:0] IDX_HI  = FLD_W'(23);
    localparam logic [FLD_W-1:0] ABS_IND = FLD_W'(30);
    localparam logic [FLD_W-1:0] ABS_LIT = FLD_W'(31);

    always_comb begin
        hit = ((code >= IDX_LO) && (code <= IDX_HI)) ||
              (code == ABS_IND) || (code == ABS_LIT);
    end
endmodule

// File: rtl/ctl_decode.sv
module ctl_decode
    import instr_step_pkg::*;
#(
    parameter int OPC_W = 4,
    parameter int FLD_W = 6,
    parameter int LEN_W = 2,
    parameter int CYC_W = 3,
    localparam int WORD_W = OPC_W + 2 * FLD_W
) (
    input  logic [WORD_W-1:0] word,
    input  logic              test_fail,
    output logic              nonbasic,
    output logic [OPC_W-1:0]  opc,
    output logic [FLD_W-1:0]  xop,
    output logic [FLD_W-1:0]  fa,
    output logic [FLD_W-1:0]  fb,
    output logic [LEN_W-1:0]  len,
    output logic [CYC_W-1:0]  cyc,
    output logic              is_test,
    output logic              illegal
);
    logic [1:0] nw;

    // one extra-word detector per operand slot
    for (genvar s = 0; s < 2; s++) begin : g_slot
        ctl_nxw #(.FLD_W(FLD_W)) u_nxw (
            .code (word[OPC_W + s*FLD_W +: FLD_W]),
            .hit  (nw[s])
        );
    end

    logic [FLD_W-1:0] slot0, slot1;
    logic [CYC_W-1:0] base;

    always_comb begin
        slot0    = word[OPC_W +: FLD_W];
        slot1    = word[OPC_W + FLD_W +: FLD_W];
        nonbasic = (word[OPC_W-1:0] == '0);
        opc      = word[OPC_W-1:0];
        xop      = '0;
        fa       = slot0;
        fb       = slot1;
        is_test  = 1'b0;
        illegal  = 1'b0;
        base     = CYC_W'(base_cost(word[3:0]));
        if (nonbasic) begin
            xop     = slot0;
            fa      = slot1;
            fb      = '0;
            illegal = (slot0 != FLD_W'(XOP_CALL));
            if (illegal) begin
                len = LEN_W'(1);
                cyc = CYC_W'(1);
            end else begin
                len = LEN_W'(1) + LEN_W'(nw[1]);
                cyc = CYC_W'(2) + CYC_W'(nw[1]);
            end
        end else begin
            is_test = is_test_op(word[3:0]);
            len = LEN_W'(1) + LEN_W'(nw[0]) + LEN_W'(nw[1]);
            cyc = base + CYC_W'(nw[0]) + CYC_W'(nw[1]) +
                  CYC_W'(is_test & test_fail);
        end
    end
endmodule

// File: rtl/instr_step_ctl.sv
module instr_step_ctl #(
    parameter int OPC_W = 4,
    parameter int FLD_W = 6,
    parameter int LEN_W = 2,
    parameter int CYC_W = 3,
    localparam int WORD_W = OPC_W + 2 * FLD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_test_fail,
    input  logic              in_skip_req,
    output logic              out_valid,
    output logic              out_nonbasic,
    output logic [OPC_W-1:0]  out_opcode,
    output logic [FLD_W-1:0]  out_xop,
    output logic [FLD_W-1:0]  out_opnd_a,
    output logic [FLD_W-1:0]  out_opnd_b,
    output logic [LEN_W-1:0]  out_len,
    output logic [CYC_W-1:0]  out_cycles,
    output logic [LEN_W-1:0]  out_pc_adv,
    output logic              out_skipped,
    output logic              out_illegal,
    output logic              out_skip_next
);
    typedef struct packed {
        logic             vld;
        logic             nb;
        logic [OPC_W-1:0] opc;
        logic [FLD_W-1:0] xop;
        logic [FLD_W-1:0] fa;
        logic [FLD_W-1:0] fb;
        logic [LEN_W-1:0] len;
        logic [CYC_W-1:0] cyc;
        logic             skipped;
        logic             illegal;
        logic             pend;
    } st_t;

    st_t st_d, st_q;

    logic             dec_nb, dec_test, dec_ill;
    logic [OPC_W-1:0] dec_opc;
    logic [FLD_W-1:0] dec_xop, dec_fa, dec_fb;
    logic [LEN_W-1:0] dec_len;
    logic [CYC_W-1:0] dec_cyc;

    ctl_decode #(
        .OPC_W(OPC_W), .FLD_W(FLD_W), .LEN_W(LEN_W), .CYC_W(CYC_W)
    ) u_dec (
        .word      (in_word),
        .test_fail (in_test_fail),
        .nonbasic  (dec_nb),
        .opc       (dec_opc),
        .xop       (dec_xop),
        .fa        (dec_fa),
        .fb        (dec_fb),
        .len       (dec_len),
        .cyc       (dec_cyc),
        .is_test   (dec_test),
        .illegal   (dec_ill)
    );

    logic skip_now;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        skip_now = st_q.pend | in_skip_req;
        if (in_valid) begin
            st_d.vld     = 1'b1;
            st_d.nb      = dec_nb;
            st_d.opc     = dec_opc;
            st_d.xop     = dec_xop;
            st_d.fa      = dec_fa;
            st_d.fb      = dec_fb;
            st_d.len     = dec_len;
            st_d.cyc     = skip_now ? '0 : dec_cyc;
            st_d.skipped = skip_now;
            st_d.illegal = dec_ill;
            st_d.pend    = ~skip_now & dec_test & in_test_fail;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid     = st_q.vld;
    assign out_nonbasic  = st_q.nb;
    assign out_opcode    = st_q.opc;
    assign out_xop       = st_q.xop;
    assign out_opnd_a    = st_q.fa;
    assign out_opnd_b    = st_q.fb;
    assign out_len       = st_q.len;
    assign out_cycles    = st_q.cyc;
    assign out_pc_adv    = st_q.len;
    assign out_skipped   = st_q.skipped;
    assign out_illegal   = st_q.illegal;
    assign out_skip_next = st_q.pend;

    // R11
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_skip_next)));
    // R8
    skip_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec_test && in_test_fail && !out_skip_next && !in_skip_req)
        |=> out_skip_next);
    // R10
    skip_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && out_skip_next) |=> (out_skipped && !out_skip_next));
    // R5
    skipped_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_skipped) |-> (out_cycles == '0));
    // R7
    illegal_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_illegal) |-> (out_len == LEN_W'(1)));
    // R3
    len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len != '0));
endmodule

// File: tb/sim_instr_step_ctl.sv
module sim_instr_step_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = '0;
    logic        in_test_fail = 1'b0;
    logic        in_skip_req = 1'b0;
    logic        out_valid, out_nonbasic, out_skipped, out_illegal, out_skip_next;
    logic [3:0]  out_opcode;
    logic [5:0]  out_xop, out_opnd_a, out_opnd_b;
    logic [1:0]  out_len, out_pc_adv;
    logic [2:0]  out_cycles;

    int total = 0;
    int bad = 0;
    bit pend = 0;

    always #4 clk = ~clk;

    instr_step_ctl u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .in_test_fail(in_test_fail), .in_skip_req(in_skip_req),
        .out_valid(out_valid), .out_nonbasic(out_nonbasic),
        .out_opcode(out_opcode), .out_xop(out_xop),
        .out_opnd_a(out_opnd_a), .out_opnd_b(out_opnd_b),
        .out_len(out_len), .out_cycles(out_cycles), .out_pc_adv(out_pc_adv),
        .out_skipped(out_skipped), .out_illegal(out_illegal),
        .out_skip_next(out_skip_next)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int xw(input logic [5:0] c);
        return ((c >= 6'h10 && c <= 6'h17) || c == 6'h1e || c == 6'h1f) ? 1 : 0;
    endfunction

    task automatic apply(input logic [15:0] w, input bit tf, input bit sr);
        bit nb, ill, tst, skp;
        int len, cyc;
        string ctag;
        in_word = w; in_test_fail = tf; in_skip_req = sr; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        nb  = (w[3:0] == 4'h0);
        ill = nb && (w[9:4] != 6'h01);
        tst = !nb && (w[3:0] >= 4'hc);
        skp = pend | sr;
        if (nb) begin
            len  = ill ? 1 : 1 + xw(w[15:10]);
            cyc  = ill ? 1 : 2 + xw(w[15:10]);
            ctag = ill ? "R7 cost" : "R6 cost";
        end else begin
            len = 1 + xw(w[9:4]) + xw(w[15:10]);
            case (w[3:0])
                4'h1, 4'h9, 4'ha, 4'hb:       cyc = 1;
                4'h2, 4'h3, 4'h4, 4'h7, 4'h8: cyc = 2;
                4'h5, 4'h6:                   cyc = 3;
                default:                      cyc = 2 + int'(tf);
            endcase
            cyc  = cyc + xw(w[9:4]) + xw(w[15:10]);
            ctag = tst ? "R5 cost" : "R4 cost";
        end
        if (skp) begin cyc = 0; ctag = "R5 skipped cost"; end
        chk("R11 valid", out_valid, 1);
        chk("R2 format", out_nonbasic, nb);
        chk("R2 opcode", out_opcode, nb ? 0 : w[3:0]);
        chk("R2 xop", out_xop, nb ? w[9:4] : 0);
        chk("R2 opnd_a", out_opnd_a, nb ? w[15:10] : w[9:4]);
        chk("R2 opnd_b", out_opnd_b, nb ? 0 : w[15:10]);
        chk("R3 len", out_len, len);
        chk("R3 pc_adv", out_pc_adv, len);
        chk(ctag, out_cycles, cyc);
        chk(sr ? "R9 skipped" : "R8 skipped", out_skipped, skp);
        chk("R7 illegal", out_illegal, ill);
        pend = !skp && tst && tf;
        chk("R10 skip_next", out_skip_next, pend);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid", out_valid, 0);
        chk("R1 skip_next", out_skip_next, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after release", out_valid, 0);

        // two-operand sweep over every opcode and operand pair
        for (int op = 1; op < 16; op++)
            for (int a = 0; a < 64; a++)
                for (int b = 0; b < 64; b++)
                    apply({b[5:0], a[5:0], op[3:0]}, a[0] ^ b[1], (a == b) && (op[1:0] == 2'd1));

        // extended-format sweep
        for (int x = 0; x < 64; x++)
            for (int a = 0; a < 64; a++)
                apply({a[5:0], x[5:0], 4'h0}, x[0], 1'b0);

        // R8: failing test arms a skip; R11: idle cycles keep it
        apply({6'h1f, 6'h00, 4'hc}, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        chk("R11 idle valid", out_valid, 0);
        chk("R11 idle skip held", out_skip_next, 1);
        // R10: skipped failing test does not re-arm
        apply({6'h1e, 6'h10, 4'hd}, 1'b1, 1'b0);
        chk("R10 no chain", out_skip_next, 0);
        // R9: forced skip of a three-word move
        apply({6'h1f, 6'h17, 4'h1}, 1'b0, 1'b1);
        // R8: test_fail ignored on non-test opcode
        apply({6'h00, 6'h01, 4'h2}, 1'b1, 1'b0);
        chk("R8 ignored fail", out_skip_next, 0);
        // R7: reserved extended opcode while skipped
        apply({6'h20, 6'h00, 4'hf}, 1'b1, 1'b0);
        apply({6'h1f, 6'h02, 4'h0}, 1'b0, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule